// File: doc/BRIEF.md
# Sensor Bus Attention Request Controller

This block sits in a slave on a shared single-wire sensor bus. It decides when the slave should pull the master's attention. Two kinds of event can start a request. The first is a function event that has set a status flag. The second is a bus error. Each event waits in its own pending latch until the bus is next idle. At that first idle cycle the controller either issues a one-cycle request strobe to the physical signalling layer or drops the pending function event.

Function-event requests are rationed to one per status-read epoch. Once any device has produced an attention request on the bus, including this slave, further function-event requests are withheld. They are allowed again only after a read of the device status register or a bus reset. Bus-error requests ignore that ration, and only a bus reset that arrives before the bus goes idle cancels them.

All pins are plain control levels and strobes. There is no data path, so no valid/ready handshake and no back-pressure. The request strobe is registered and has no acknowledge.

Top module: `attn_req_ctrl`

## Requirements
- R1: A function event with the enable high is latched. The first cycle in which `bus_idle_i` is high and the latch is set is the evaluation cycle. If the request is allowed, `attn_req_o` is high in the cycle that follows. An event that arrives while the bus is already idle is evaluated in the next cycle.
- R2: A function event that arrives while `attn_en_i` is low is ignored and leaves no pending state.
- R3: A function-event request is suppressed if an attention request has appeared on the bus since the last status read or bus reset. This covers `bus_attn_seen_i` from any device as well as this block's own issued request. A pending function event that is suppressed at its evaluation cycle is discarded and never retried.
- R4: A status-register read (`status_rd_i`) ends the suppression from the following cycle.
- R5: A bus reset (`bus_reset_i`) also ends the suppression from the following cycle.
- R6: A pending bus error produces a request at the first idle cycle whatever the suppression state is, unless a bus reset is present in that cycle.
- R7: A bus reset that occurs after a bus error and no later than its first idle cycle cancels that error, and no request follows.
- R8: When both kinds of event fire in the same cycle, a single strobe is issued and both latches clear. An event that arrives in the issuing cycle is merged into that strobe.
- R9: `attn_req_o` is never high for two consecutive cycles.
- R10: A synchronous active-high `rst` clears both latches and the suppression flag, and holds `attn_req_o` low.
- R11: If a status read and an observed bus attention request fall in the same cycle, the suppression is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_event_i | input | 1 | Strobe: a function event set the status flag |
| attn_en_i | input | 1 | Attention requests enabled |
| bus_err_i | input | 1 | Strobe: bus error detected |
| bus_idle_i | input | 1 | Level: bit receiver reports the bus inactive |
| status_rd_i | input | 1 | Strobe: device status register was read |
| bus_reset_i | input | 1 | Strobe: bus reset received |
| bus_attn_seen_i | input | 1 | Strobe: an attention request was observed on the bus |
| attn_req_o | output | 1 | One-cycle request to the signalling layer |

## Verification
The hardest case to reach from the ports is a function event that is discarded by suppression and must stay lost after the suppression is lifted. To reach it, the stimulus sets the suppression, lets the bus go idle to consume the event, then reads status and idles again while checking that no strobe appears. A second hard case is the same-cycle collisions. These are a status read coinciding with a bus attention, a bus reset in the idle cycle of a pending error, and a new error arriving in the very cycle a request issues. Each of these is produced by directed cycles after the vector table.

// File: rtl/attn_pkg.sv
package attn_pkg;

  // Which pending kinds fire in an evaluation cycle
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_FN   = 2'd1,
    CAUSE_ERR  = 2'd2,
    CAUSE_BOTH = 2'd3
  } attn_cause_e;

endpackage

// File: rtl/attn_pend_latch.sv
module attn_pend_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic consume_i,
  output logic pend_o
);

  logic pend_q;

  // Clear outranks consume, consume outranks set: an arrival in the
  // consuming cycle is absorbed into that cycle's decision.
  always_ff @(posedge clk) begin
    if (rst)            pend_q <= 1'b0;
    else if (clr_i)     pend_q <= 1'b0;
    else if (consume_i) pend_q <= 1'b0;
    else if (set_i)     pend_q <= 1'b1;
  end

  assign pend_o = pend_q;

  AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
    consume_i |=> !pend_o); // R8

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !pend_o); // R7

endmodule

// File: rtl/attn_suppress.sv
module attn_suppress (
  input  logic clk,
  input  logic rst,
  input  logic status_rd_i,
  input  logic bus_reset_i,
  input  logic seen_i,
  input  logic own_fire_i,
  output logic supp_o
);

  logic supp_q;
  logic set_w;
  logic clr_w;

  assign set_w = seen_i | own_fire_i;
  assign clr_w = status_rd_i | bus_reset_i;

  // A request in the same cycle as a clearing event wins (R11)
  always_ff @(posedge clk) begin
    if (rst)        supp_q <= 1'b0;
    else if (set_w) supp_q <= 1'b1;
    else if (clr_w) supp_q <= 1'b0;
  end

  assign supp_o = supp_q;

  AST_EPOCH_RESTART: assert property (@(posedge clk) disable iff (rst)
    (status_rd_i && !seen_i && !own_fire_i) |=> !supp_o); // R4

  AST_BRST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_i && !seen_i && !own_fire_i) |=> !supp_o); // R5

  AST_SEEN_SUPPRESSES: assert property (@(posedge clk) disable iff (rst)
    seen_i |=> supp_o); // R3

endmodule

// File: rtl/attn_issue.sv
module attn_issue
  import attn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fn_pend_i,
  input  logic err_pend_i,
  input  logic bus_idle_i,
  input  logic supp_i,
  input  logic bus_reset_i,
  output logic fn_consume_o,
  output logic err_consume_o,
  output logic fire_o,
  output logic req_o
);

  logic        fire_fn;
  logic        fire_err;
  attn_cause_e cause;
  logic        req_q;

  always_comb begin
    fire_fn  = fn_pend_i & bus_idle_i & ~supp_i;
    fire_err = err_pend_i & bus_idle_i & ~bus_reset_i;
    unique case ({fire_err, fire_fn})
      2'b00:   cause = CAUSE_NONE;
      2'b01:   cause = CAUSE_FN;
      2'b10:   cause = CAUSE_ERR;
      default: cause = CAUSE_BOTH;
    endcase
    fire_o        = (cause != CAUSE_NONE);
    // A function event is judged once, at its first idle cycle
    fn_consume_o  = (fn_pend_i & bus_idle_i) | fire_o;
    err_consume_o = fire_o;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= fire_o;
  end

  assign req_o = req_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o); // R9

  AST_IDLE_BEFORE_REQ: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $past(bus_idle_i)); // R1

  AST_ERR_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (err_pend_i && bus_idle_i && !bus_reset_i) |=> req_o); // R6

  AST_SUPP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (supp_i && !err_pend_i) |=> !req_o); // R3

endmodule

// File: rtl/attn_req_ctrl.sv
module attn_req_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic fn_event_i,
  input  logic attn_en_i,
  input  logic bus_err_i,
  input  logic bus_idle_i,
  input  logic status_rd_i,
  input  logic bus_reset_i,
  input  logic bus_attn_seen_i,
  output logic attn_req_o
);

  logic fn_pend;
  logic err_pend;
  logic fn_consume;
  logic err_consume;
  logic own_fire;
  logic supp;
  logic fn_set;

  assign fn_set = fn_event_i & attn_en_i;

  attn_pend_latch u_fn_latch (
    .clk       (clk),
    .rst       (rst),
    .set_i     (fn_set),
    .clr_i     (1'b0),
    .consume_i (fn_consume),
    .pend_o    (fn_pend)
  );

  attn_pend_latch u_err_latch (
    .clk       (clk),
    .rst       (rst),
    .set_i     (bus_err_i),
    .clr_i     (bus_reset_i),
    .consume_i (err_consume),
    .pend_o    (err_pend)
  );

  attn_suppress u_supp (
    .clk         (clk),
    .rst         (rst),
    .status_rd_i (status_rd_i),
    .bus_reset_i (bus_reset_i),
    .seen_i      (bus_attn_seen_i),
    .own_fire_i  (own_fire),
    .supp_o      (supp)
  );

  attn_issue u_issue (
    .clk           (clk),
    .rst           (rst),
    .fn_pend_i     (fn_pend),
    .err_pend_i    (err_pend),
    .bus_idle_i    (bus_idle_i),
    .supp_i        (supp),
    .bus_reset_i   (bus_reset_i),
    .fn_consume_o  (fn_consume),
    .err_consume_o (err_consume),
    .fire_o        (own_fire),
    .req_o         (attn_req_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !attn_req_o); // R10

  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (fn_event_i && !attn_en_i && !fn_pend) |=> !fn_pend); // R2

endmodule

// File: tb/tb_attn_req_ctrl.sv
module tb_attn_req_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 50;

  logic clk = 1'b0;
  logic rst;
  logic fn_event_i, attn_en_i, bus_err_i, bus_idle_i;
  logic status_rd_i, bus_reset_i, bus_attn_seen_i;
  logic attn_req_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  attn_req_ctrl dut (
    .clk             (clk),
    .rst             (rst),
    .fn_event_i      (fn_event_i),
    .attn_en_i       (attn_en_i),
    .bus_err_i       (bus_err_i),
    .bus_idle_i      (bus_idle_i),
    .status_rd_i     (status_rd_i),
    .bus_reset_i     (bus_reset_i),
    .bus_attn_seen_i (bus_attn_seen_i),
    .attn_req_o      (attn_req_o)
  );

  // Bits: [7] fn [6] en [5] err [4] idle [3] rd [2] brst [1] seen [0] expected req
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1100_0000, 8'b0001_0000, 8'b0001_0001, 8'b0001_0000,  // R1, R9
    8'b1100_0000, 8'b0001_0000, 8'b0001_0000,                // R3 own request
    8'b0000_1000, 8'b1100_0000, 8'b0001_0000, 8'b0001_0001,  // R4
    8'b0000_1000, 8'b0000_0010, 8'b1100_0000, 8'b0001_0000,
    8'b0001_0000,                                            // R3 other device
    8'b0010_0000, 8'b0001_0000, 8'b0001_0001, 8'b0001_0000,  // R6
    8'b0010_0000, 8'b0000_0100, 8'b0001_0000, 8'b0001_0000,  // R7
    8'b1100_0000, 8'b0001_0000, 8'b0001_0001,                // R5
    8'b0000_1000, 8'b1000_0000, 8'b0001_0000, 8'b0001_0000,  // R2
    8'b1100_0000, 8'b0001_0000, 8'b0001_0001,
    8'b0000_1000, 8'b1110_0000, 8'b0001_0000, 8'b0001_0001,  // R8
    8'b0001_0000, 8'b0001_0000,
    8'b1100_0000, 8'b0001_0000, 8'b0000_1000, 8'b0001_0000,  // R3 no retry
    8'b0001_0000, 8'b0001_0000,
    8'b0001_1000, 8'b1101_0000, 8'b0001_0000, 8'b0001_0001   // R1 already idle
  };

  localparam int VREQ [NVEC] = '{
    1, 1, 1, 9,
    3, 3, 3,
    4, 4, 4, 4,
    3, 3, 3, 3, 3,
    6, 6, 6, 9,
    7, 7, 7, 7,
    5, 5, 5,
    2, 2, 2, 2, 2, 2, 2,
    8, 8, 8, 8, 8, 8,
    3, 3, 3, 3, 3, 3,
    1, 1, 1, 1
  };

  task automatic drive(input logic [6:0] v);
    {fn_event_i, attn_en_i, bus_err_i, bus_idle_i,
     status_rd_i, bus_reset_i, bus_attn_seen_i} = v;
  endtask

  task automatic check(input logic exp, input string tag);
    n_tests++;
    if (attn_req_o !== exp) begin
      n_fail++;
      $display("FAIL %s: attn_req_o=%b expected=%b at %0t", tag, attn_req_o, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, check the registered output there
  task automatic cyc(input logic [6:0] v, input logic exp, input string tag);
    @(negedge clk);
    drive(v);
    check(exp, tag);
  endtask

  initial begin
    rst = 1'b1;
    drive(7'b0000000);
    // R10: output quiet while reset is held, even with events and idle bus
    repeat (2) @(negedge clk);
    drive(7'b1111000);
    repeat (2) begin
      @(negedge clk);
      check(1'b0, "R10");
    end
    @(negedge clk);
    drive(7'b0000000);
    rst = 1'b0;
    check(1'b0, "R10");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i][7:1]);
      n_tests++;
      if (attn_req_o !== VEC[i][0]) begin
        n_fail++;
        $display("FAIL R%0d: vector %0d attn_req_o=%b expected=%b",
                 VREQ[i], i, attn_req_o, VEC[i][0]);
      end
    end

    // R11: status read coinciding with a bus attention leaves suppression set
    cyc(7'b0000100, 1'b0, "R11");
    cyc(7'b0000101, 1'b0, "R11");
    cyc(7'b1100000, 1'b0, "R11");
    cyc(7'b0001000, 1'b0, "R11");
    cyc(7'b0001000, 1'b0, "R11");
    cyc(7'b0001000, 1'b0, "R11");
    // R4: a plain read then lets a new event through
    cyc(7'b0000100, 1'b0, "R4");
    cyc(7'b1100000, 1'b0, "R4");
    cyc(7'b0001000, 1'b0, "R4");
    cyc(7'b0001000, 1'b1, "R4");

    // R7: bus reset in the very idle cycle of a pending error cancels it
    cyc(7'b0010000, 1'b0, "R7");
    cyc(7'b0001010, 1'b0, "R7");
    cyc(7'b0001000, 1'b0, "R7");
    cyc(7'b0001000, 1'b0, "R7");

    // R8/R9: new error in the issuing cycle is merged, no second strobe
    cyc(7'b0010000, 1'b0, "R8");
    cyc(7'b0011000, 1'b0, "R8");
    cyc(7'b0001000, 1'b1, "R8");
    cyc(7'b0001000, 1'b0, "R9");
    cyc(7'b0001000, 1'b0, "R9");

    // R10: reset drops a pending error and clears suppression
    cyc(7'b0010000, 1'b0, "R10");
    @(negedge clk);
    drive(7'b0000000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(7'b0001000);
    check(1'b0, "R10");
    cyc(7'b0001000, 1'b0, "R10");
    cyc(7'b0001000, 1'b0, "R10");
    cyc(7'b1100000, 1'b0, "R10");
    cyc(7'b0001000, 1'b0, "R10");
    cyc(7'b0001000, 1'b1, "R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule